// File: doc/BRIEF.md
# Per-CPU Doorbell Unit

This block holds a 32-bit doorbell cause register and a 32-bit doorbell enable register for every CPU of a cluster. It turns them into two interrupt request lines per CPU. The low eight doorbells carry signals between processors. The upper sixteen doorbells (numbers 16 to 31) carry message-signalled interrupts from devices. Doorbell numbers 8 to 15 are reserved and are never stored.

Software raises a doorbell by writing one shared trigger word. The word names a doorbell number and a bitmap of the CPUs that should receive it. A device does the same by posting a message word on a separate message-write port; that word has the same layout. Each CPU reads, clears and masks only its own copy of the registers. The copy is selected by the CPU id that travels with every register access. A CPU clears pending doorbells by writing zeros into the matching cause bits. The two request lines per CPU feed the first two source inputs of the surrounding interrupt controller.

Top module: `dbell_unit`

## Requirements
- R1: After reset every cause and enable register reads as zero and both request lines of every CPU are low.
- R2: A register write to offset 0x04 sets the doorbell given by data bits [4:0] in the cause register of every CPU whose bit is set in the target bitmap at data bits [11:8] (bit 8 is CPU 0).
- R3: A trigger whose doorbell number lies in 8..15, or whose target bitmap is empty, leaves every cause register unchanged, and cause bits [15:8] always read as zero.
- R4: A message write uses the same word layout as the trigger, so the word 0xF00 | (k + 16) for k in 0..15 sets doorbell k+16 in all four CPUs.
- R5: A register write to offset 0x08 changes only the writer's cause register: each bit written as 0 is cleared and each bit written as 1 keeps its value.
- R6: Offset 0x0C holds an enable register for each CPU, written only by that CPU; bits [7:0] and [31:16] store the written value and bits [15:8] read as zero.
- R7: The processor-signal request line of a CPU is high exactly when some cause bit in [7:0] and the matching enable bit are both set.
- R8: The message request line of a CPU is high exactly when some cause bit in [31:16] and the matching enable bit are both set.
- R9: When a message write sets a doorbell in the same cycle that the CPU's cause write would clear it, the doorbell ends up set.
- R10: A read with bus_rd_i high returns on bus_rdata_o in the next cycle the reading CPU's cause (0x08) or enable (0x0C) value; any other offset reads as zero.
- R11: Register state and request lines change in the clock edge that takes the write, with no further delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_cpu_i | input | CPU_W | CPU id of the accessing processor |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid one cycle after bus_rd_i |
| msg_vld_i | input | 1 | Message write strobe |
| msg_data_i | input | 32 | Message word (trigger layout) |
| irq_ipi_o | output | NUM_CPU | Per-CPU processor-signal request line |
| irq_msi_o | output | NUM_CPU | Per-CPU message request line |

## Verification
The assertions watch every cycle for these properties: a valid trigger or message reaches each targeted cause register, a zero-bit cause write clears only the writer's copy, a colliding message set survives the clear, the reserved range stays empty, an enable write leaves other CPUs' enable registers alone, and a request line never rises without both a pending cause bit and its enable bit. The sweeps are needed for the rest: every doorbell number under changing target bitmaps, all sixteen message words, and exact read-back values and request-line levels after each step. Those values are compared against a model built from the requirements.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

  localparam int DB_W    = 32;
  localparam int NUM_W   = 5;
  localparam int IPI_N   = 8;
  localparam int MSI_LO  = 16;
  localparam int MSI_N   = 16;

  localparam int OFF_TRIG  = 4;
  localparam int OFF_CAUSE = 8;
  localparam int OFF_MASK  = 12;

  function automatic logic [DB_W-1:0] impl_bits();
    logic [DB_W-1:0] b;
    for (int i = 0; i < DB_W; i++) begin
      b[i] = (i < IPI_N) || (i >= MSI_LO);
    end
    return b;
  endfunction

  localparam logic [DB_W-1:0] IMPL = impl_bits();

  function automatic logic db_num_ok(logic [NUM_W-1:0] n);
    return (int'(n) < IPI_N) || (int'(n) >= MSI_LO);
  endfunction

endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
  import dbell_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int MAP_LSB = 8
) (
  input  logic                           valid_i,
  input  logic [DB_W-1:0]                word_i,
  output logic [NUM_CPU-1:0][DB_W-1:0]   set_o
);

  localparam int MAP_MSB = MAP_LSB + NUM_CPU - 1;

  logic [NUM_W-1:0]   num;
  logic [NUM_CPU-1:0] map;
  logic               num_ok;
  logic [DB_W-1:0]    onehot;
  logic               unused_word;

  assign num    = word_i[NUM_W-1:0];
  assign map    = word_i[MAP_MSB:MAP_LSB];
  assign num_ok = db_num_ok(num);
  assign unused_word = ^{word_i[DB_W-1:MAP_MSB+1], word_i[MAP_LSB-1:NUM_W]};

  always_comb begin
    onehot = '0;
    onehot[num] = 1'b1;
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assign set_o[c] = (valid_i && num_ok && map[c]) ? onehot : '0;
  end

endmodule

// File: rtl/dbell_bank.sv
module dbell_bank
  import dbell_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [DB_W-1:0] set_i,
  input  logic            cause_wr_i,
  input  logic            mask_wr_i,
  input  logic [DB_W-1:0] wdata_i,
  output logic [DB_W-1:0] cause_o,
  output logic [DB_W-1:0] mask_o,
  output logic            irq_ipi_o,
  output logic            irq_msi_o
);

  logic [DB_W-1:0] cause_q, cause_d;
  logic [DB_W-1:0] mask_q, mask_d;
  logic [DB_W-1:0] keep;
  logic            cause_en, mask_en;

  always_comb begin
    keep     = cause_wr_i ? wdata_i : '1;
    cause_d  = ((cause_q & keep) | set_i) & IMPL;
    cause_en = cause_wr_i | (|set_i);
    mask_d   = wdata_i & IMPL;
    mask_en  = mask_wr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
    end else if (cause_en) begin
      cause_q <= cause_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  assign cause_o   = cause_q;
  assign mask_o    = mask_q;
  assign irq_ipi_o = |(cause_q[IPI_N-1:0] & mask_q[IPI_N-1:0]);
  assign irq_msi_o = |(cause_q[MSI_LO +: MSI_N] & mask_q[MSI_LO +: MSI_N]);

endmodule

// File: rtl/dbell_rdmux.sv
module dbell_rdmux
  import dbell_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 8,
  parameter int CPU_W   = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          rd_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [CPU_W-1:0]              cpu_i,
  input  logic [NUM_CPU-1:0][DB_W-1:0]  cause_i,
  input  logic [NUM_CPU-1:0][DB_W-1:0]  mask_i,
  output logic [DB_W-1:0]               rdata_o
);

  logic [DB_W-1:0] rdata_d, rdata_q;

  always_comb begin
    rdata_d = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (cpu_i == CPU_W'(c)) begin
        if (addr_i == ADDR_W'(OFF_CAUSE)) rdata_d = cause_i[c];
        if (addr_i == ADDR_W'(OFF_MASK))  rdata_d = mask_i[c];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/dbell_unit.sv
module dbell_unit
  import dbell_pkg::*;
#(
  parameter  int NUM_CPU = 4,
  parameter  int ADDR_W  = 8,
  parameter  int MAP_LSB = 8,
  localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [CPU_W-1:0]   bus_cpu_i,
  input  logic [DB_W-1:0]    bus_wdata_i,
  output logic [DB_W-1:0]    bus_rdata_o,
  input  logic               msg_vld_i,
  input  logic [DB_W-1:0]    msg_data_i,
  output logic [NUM_CPU-1:0] irq_ipi_o,
  output logic [NUM_CPU-1:0] irq_msi_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n_q = rst_sync_q[1];

  // address decode
  logic hit_trig, hit_cause, hit_mask;

  assign hit_trig  = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_TRIG));
  assign hit_cause = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_CAUSE));
  assign hit_mask  = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_MASK));

  logic [NUM_CPU-1:0][DB_W-1:0] bus_set, msg_set;
  logic [NUM_CPU-1:0][DB_W-1:0] cause_all, mask_all;

  dbell_decode #(.NUM_CPU(NUM_CPU), .MAP_LSB(MAP_LSB)) u_dec_bus (
    .valid_i (hit_trig),
    .word_i  (bus_wdata_i),
    .set_o   (bus_set)
  );

  dbell_decode #(.NUM_CPU(NUM_CPU), .MAP_LSB(MAP_LSB)) u_dec_msg (
    .valid_i (msg_vld_i),
    .word_i  (msg_data_i),
    .set_o   (msg_set)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
    logic own;
    assign own = (bus_cpu_i == CPU_W'(c));

    dbell_bank u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_n_q),
      .set_i      (bus_set[c] | msg_set[c]),
      .cause_wr_i (hit_cause && own),
      .mask_wr_i  (hit_mask && own),
      .wdata_i    (bus_wdata_i),
      .cause_o    (cause_all[c]),
      .mask_o     (mask_all[c]),
      .irq_ipi_o  (irq_ipi_o[c]),
      .irq_msi_o  (irq_msi_o[c])
    );
  end

  dbell_rdmux #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .CPU_W(CPU_W)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_q),
    .rd_i    (bus_rd_i),
    .addr_i  (bus_addr_i),
    .cpu_i   (bus_cpu_i),
    .cause_i (cause_all),
    .mask_i  (mask_all),
    .rdata_o (bus_rdata_o)
  );

endmodule

// File: rtl/dbell_unit_chk.sv
module dbell_unit_chk
  import dbell_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 8,
  parameter int MAP_LSB = 8,
  parameter int CPU_W   = 2
) (
  input logic                          clk_i,
  input logic                          rst_n,
  input logic                          bus_wr_i,
  input logic [ADDR_W-1:0]             bus_addr_i,
  input logic [CPU_W-1:0]              bus_cpu_i,
  input logic [DB_W-1:0]               bus_wdata_i,
  input logic                          msg_vld_i,
  input logic [DB_W-1:0]               msg_data_i,
  input logic [NUM_CPU-1:0][DB_W-1:0]  cause_all,
  input logic [NUM_CPU-1:0][DB_W-1:0]  mask_all,
  input logic [NUM_CPU-1:0]            irq_ipi_o,
  input logic [NUM_CPU-1:0]            irq_msi_o
);

  logic wr_trig, wr_cause, wr_mask;
  assign wr_trig  = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_TRIG));
  assign wr_cause = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_CAUSE));
  assign wr_mask  = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_MASK));

  AST_EMPTY_MAP_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_trig && (bus_wdata_i[MAP_LSB +: NUM_CPU] == '0) && !msg_vld_i) |=> $stable(cause_all)); // R3

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
    AST_TRIG_SETS: assert property (@(posedge clk_i) disable iff (!rst_n)
      (wr_trig && db_num_ok(bus_wdata_i[NUM_W-1:0]) && bus_wdata_i[MAP_LSB+c])
      |=> cause_all[c][$past(bus_wdata_i[NUM_W-1:0])]); // R2

    AST_MSG_SETS: assert property (@(posedge clk_i) disable iff (!rst_n)
      (msg_vld_i && db_num_ok(msg_data_i[NUM_W-1:0]) && msg_data_i[MAP_LSB+c])
      |=> cause_all[c][$past(msg_data_i[NUM_W-1:0])]); // R4

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_n)
      (msg_vld_i && db_num_ok(msg_data_i[NUM_W-1:0]) && msg_data_i[MAP_LSB+c]
       && wr_cause && (bus_cpu_i == CPU_W'(c)))
      |=> cause_all[c][$past(msg_data_i[NUM_W-1:0])]); // R9

    AST_CLEAR_ZEROS: assert property (@(posedge clk_i) disable iff (!rst_n)
      (wr_cause && (bus_cpu_i == CPU_W'(c)) && !msg_vld_i)
      |=> (cause_all[c] == ($past(cause_all[c]) & $past(bus_wdata_i)))); // R5

    AST_RSVD_CAUSE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
      cause_all[c][15:8] == 8'h00); // R3

    AST_RSVD_MASK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
      mask_all[c][15:8] == 8'h00); // R6

    AST_MASK_BANKED: assert property (@(posedge clk_i) disable iff (!rst_n)
      (wr_mask && (bus_cpu_i != CPU_W'(c))) |=> $stable(mask_all[c])); // R6

    AST_IPI_NEEDS_BOTH: assert property (@(posedge clk_i) disable iff (!rst_n)
      ((cause_all[c][IPI_N-1:0] == '0) || (mask_all[c][IPI_N-1:0] == '0)) |-> !irq_ipi_o[c]); // R7

    AST_MSI_NEEDS_BOTH: assert property (@(posedge clk_i) disable iff (!rst_n)
      ((cause_all[c][MSI_LO +: MSI_N] == '0) || (mask_all[c][MSI_LO +: MSI_N] == '0)) |-> !irq_msi_o[c]); // R8
  end

endmodule

bind dbell_unit dbell_unit_chk #(
  .NUM_CPU (NUM_CPU),
  .ADDR_W  (ADDR_W),
  .MAP_LSB (MAP_LSB),
  .CPU_W   (CPU_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_n_q),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_cpu_i   (bus_cpu_i),
  .bus_wdata_i (bus_wdata_i),
  .msg_vld_i   (msg_vld_i),
  .msg_data_i  (msg_data_i),
  .cause_all   (cause_all),
  .mask_all    (mask_all),
  .irq_ipi_o   (irq_ipi_o),
  .irq_msi_o   (irq_msi_o)
);

// File: tb/dbell_unit_bench.sv
`timescale 1ns/1ps
module dbell_unit_bench;

  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bwr, brd, mv;
  logic [7:0]  baddr;
  logic [1:0]  bcpu;
  logic [31:0] bwd, md, brd_data;
  logic [NC-1:0] ipi, msi;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [31:0] exp_cause [NC];
  logic [31:0] exp_mask  [NC];

  always #2.5 clk = ~clk;

  dbell_unit u_dbell_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_wr_i(bwr), .bus_rd_i(brd), .bus_addr_i(baddr), .bus_cpu_i(bcpu),
    .bus_wdata_i(bwd), .bus_rdata_o(brd_data),
    .msg_vld_i(mv), .msg_data_i(md),
    .irq_ipi_o(ipi), .irq_msi_o(msi)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] dec(logic v, logic [31:0] w, int c);
    int n = int'(w[4:0]);
    if (v && (n < 8 || n >= 16) && w[8+c]) return 32'h1 << n;
    return 32'h0;
  endfunction

  // one bus/message cycle; called and returning at a falling edge
  task automatic step(logic w, int cpu, int addr, logic [31:0] data, logic v, logic [31:0] m);
    bwr = w; baddr = 8'(addr); bcpu = 2'(cpu); bwd = data; mv = v; md = m;
    @(negedge clk);
    bwr = 1'b0; mv = 1'b0;
    for (int c = 0; c < NC; c++) begin
      logic [31:0] s, keep;
      s = dec(w && addr == 4, data, c) | dec(v, m, c);
      keep = (w && addr == 8 && cpu == c) ? data : 32'hFFFF_FFFF;
      exp_cause[c] = (exp_cause[c] & keep) | s;
      if (w && addr == 12 && cpu == c) exp_mask[c] = data & 32'hFFFF_00FF;
    end
  endtask

  task automatic bus_read(int cpu, int addr, output logic [31:0] val);
    brd = 1'b1; baddr = 8'(addr); bcpu = 2'(cpu);
    @(negedge clk);
    brd = 1'b0;
    val = brd_data;
  endtask

  task automatic check_state(string cause_tag);
    logic [31:0] v;
    for (int c = 0; c < NC; c++) begin
      bus_read(c, 8, v);
      chk(cause_tag, v, exp_cause[c]);
      bus_read(c, 12, v);
      chk("R6", v, exp_mask[c]);
      chk("R7", 32'(ipi[c]), 32'(|(exp_cause[c][7:0] & exp_mask[c][7:0])));
      chk("R8", 32'(msi[c]), 32'(|(exp_cause[c][31:16] & exp_mask[c][31:16])));
    end
  endtask

  task automatic clear_all();
    for (int c = 0; c < NC; c++) step(1'b1, c, 8, 32'h0, 1'b0, 32'h0);
  endtask

  initial begin
    logic [31:0] v;
    bwr = 0; brd = 0; mv = 0; baddr = 0; bcpu = 0; bwd = 0; md = 0;
    for (int c = 0; c < NC; c++) begin exp_cause[c] = 0; exp_mask[c] = 0; end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check_state("R1");
    chk("R1", 32'(ipi), 32'h0);
    chk("R1", 32'(msi), 32'h0);
    // R10: trigger and unmapped offsets read as zero
    bus_read(0, 4, v);  chk("R10", v, 32'h0);
    bus_read(1, 16, v); chk("R10", v, 32'h0);

    // R6: enable all, reserved bits drop
    for (int c = 0; c < NC; c++) step(1'b1, c, 12, 32'hFFFF_FFFF, 1'b0, 32'h0);
    check_state("R6");

    // R2/R3: every doorbell number under rotating target bitmaps
    for (int n = 0; n < 32; n++) begin
      int map = (n * 5 + 3) % 16;
      step(1'b1, n % NC, 4, 32'(map << 8) | 32'(n), 1'b0, 32'h0);
      // R11: request line visible right after the write edge
      check_state((n >= 8 && n < 16) || map == 0 ? "R3" : "R2");
      clear_all();
    end
    // R3: empty bitmap with valid number
    step(1'b1, 2, 4, 32'h0000_0003, 1'b0, 32'h0);
    check_state("R3");

    // R4: every message word, accumulated
    for (int k = 0; k < 16; k++) begin
      step(1'b0, 0, 0, 32'h0, 1'b1, 32'hF00 | 32'(k + 16));
      check_state("R4");
    end

    // R8: cpu1 enables only processor signals, message line drops
    step(1'b1, 1, 12, 32'h0000_00FF, 1'b0, 32'h0);
    check_state("R8");

    // R5: partial clear on cpu2 only
    step(1'b1, 2, 8, 32'hAAAA_00FF, 1'b0, 32'h0);
    check_state("R5");

    // R9: message set collides with cpu0 clearing everything
    step(1'b1, 0, 8, 32'h0, 1'b1, 32'hF00 | 32'd20);
    check_state("R9");
    chk("R9", exp_cause[0], 32'h0010_0000);

    // R7: cpu3 enables only doorbell 3
    clear_all();
    step(1'b1, 3, 12, 32'h0000_0008, 1'b0, 32'h0);
    step(1'b1, 0, 4, 32'h0000_0802, 1'b0, 32'h0);
    check_state("R7");
    chk("R7", 32'(ipi[3]), 32'h0);
    step(1'b1, 1, 4, 32'h0000_0803, 1'b0, 32'h0);
    check_state("R7");
    chk("R7", 32'(ipi[3]), 32'h1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule